// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block duty-cycles a radio receiver so that it spends most of its time with the analog circuits powered down. While chip select is low it alternates between a timed sleep and a short listening burst. Each burst powers the frequency synthesizer PLL and waits for it to lock. It then powers the signal-processing chain and waits for it to settle, and then opens a bit-check window on the demodulated data. A passing check latches three control bits and leaves the receiver in continuous reception, where demodulated data is passed straight to the data output. A failing check either puts the receiver back to sleep or keeps it listening, depending on the continuous-mode bit and the sleep setting.

All timing is counted in half periods of the basic clock, supplied as a one-cycle strobe `htick`. This lets the 798.5-period PLL start-up be timed exactly. The sleep time scales with a 5-bit field, a per-unit multiplier (1024 basic periods by default) and an optional extension factor. The bit-check analysis, the demodulator and the analog front end sit outside this block and reach it only through a valid/pass handshake and the data input.

Top module: `rxpoll_seq`

## Requirements
- R1: The state is visible on `phase_o` with the encoding idle=0, sleep=1, PLL start-up=2, signal-path start-up=3, bit-check=4, receive=5. Reset gives idle, and a burst always runs sleep, PLL start-up, signal-path start-up, bit-check in that order. `chk_valid` is ignored in every state but bit-check.
- R2: Sleep lasts `cfg_sleep` × SLEEP_UNIT × (XSLEEP_MULT if `cfg_xsleep` is 1, else 1) basic periods, which is twice that number of `htick` strobes. A zero sleep field gives a sleep of a single cycle.
- R3: PLL start-up lasts 1597 half periods (798.5 basic periods) for every baud range.
- R4: Signal-path start-up lasts 1764, 996, 612 or 420 half periods for `cfg_baud` = 0, 1, 2 and 3.
- R5: `rx_active`, `pll_en` and `sig_en` are low in idle and sleep. They are high from entry to PLL start-up until the next return to sleep or idle.
- R6: `chk_valid` with `chk_pass` high in bit-check moves the machine to receive on the next edge. On that edge `ctl_vsout`, `ctl_clk` and `ctl_opm0` all become 1.
- R7: `chk_valid` with `chk_pass` low in bit-check returns the machine to sleep if `ctl_opm0` is 0 and `cfg_sleep` is non-zero. Otherwise it stays in bit-check.
- R8: Idle waits for `cs_n` low and then enters sleep. At the end of sleep, a high `cs_n` sends the machine to idle instead of PLL start-up.
- R9: Receive is left only through `idle_req`, and check results have no effect there. `data_out` equals `rx_data` in receive and is 0 in every other state.
- R10: `idle_req` forces idle on the next edge from any state. On entering idle, `ctl_vsout` and `ctl_clk` clear and `ctl_opm0` takes `cfg_cont`. `ctl_opm0` keeps following `cfg_cont` while the machine stays in idle.
- R11: The timers advance only on cycles with `htick` high. With `htick` low a timed state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| htick | input | 1 | Half-basic-period strobe |
| cs_n | input | 1 | Chip select, polling allowed while low |
| cfg_sleep | input | SLEEP_W | Sleep count field |
| cfg_xsleep | input | 1 | Sleep extension enable |
| cfg_baud | input | 2 | Baud range select |
| cfg_cont | input | 1 | Continuous-mode bit loaded into `ctl_opm0` in idle |
| chk_valid | input | 1 | Bit-check result strobe |
| chk_pass | input | 1 | Bit-check result, 1 = valid transmitter |
| idle_req | input | 1 | Synchronous return to idle |
| rx_data | input | 1 | Demodulated data |
| phase_o | output | 3 | Current state code |
| rx_active | output | 1 | Receiver active indication |
| pll_en | output | 1 | PLL enable |
| sig_en | output | 1 | Signal-path enable |
| ctl_vsout | output | 1 | Supply-output enable control bit |
| ctl_clk | output | 1 | Clock-output control bit |
| ctl_opm0 | output | 1 | Operating-mode control bit |
| data_out | output | 1 | Pass-through receive data |

## Verification
The bench builds the sequencer with SLEEP_UNIT=4 and XSLEEP_MULT=2 and keeps the 5-bit sleep field. This shrinks the longest sleep to 496 half periods while the start-up delays keep their full values. It can then sweep every baud range against both extension settings and the sleep fields 0, 1 and 31, and measure each phase's length in cycles against arithmetic. Dedicated runs cover each branch after a failed check, the chip-select abort, the idle return and a timer stall with `htick` held low.

// File: rtl/rxpoll_pkg.sv
package rxpoll_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SLEEP = 3'd1,
    PH_PLL   = 3'd2,
    PH_SIG   = 3'd3,
    PH_CHK   = 3'd4,
    PH_RCV   = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    LD_SLEEP = 2'd0,
    LD_PLL   = 2'd1,
    LD_SIG   = 2'd2
  } ldsel_e;

  // PLL lock wait in half periods (798.5 basic periods)
  localparam int unsigned PLL_HALF = 1597;

  // signal-path settling wait in half periods, per baud range
  function automatic int unsigned sig_half(input logic [1:0] rng);
    case (rng)
      2'd0:    return 1764;
      2'd1:    return 996;
      2'd2:    return 612;
      default: return 420;
    endcase
  endfunction

  // sleep wait in half periods
  function automatic int unsigned sleep_half(input int unsigned field,
                                             input logic        ext,
                                             input int unsigned unit,
                                             input int unsigned mult);
    int unsigned f;
    f = ext ? mult : 1;
    return field * unit * f * 2;
  endfunction

  // counter width able to hold the longest load
  function automatic int unsigned ctr_width(input int unsigned sw,
                                            input int unsigned unit,
                                            input int unsigned mult);
    int unsigned mx;
    mx = ((1 << sw) - 1) * unit * mult * 2;
    if (mx < 1764) mx = 1764;
    return $clog2(mx + 1);
  endfunction

endpackage

// File: rtl/rxpoll_dursel.sv
module rxpoll_dursel
  import rxpoll_pkg::*;
#(
  parameter int unsigned SLEEP_W     = 5,
  parameter int unsigned SLEEP_UNIT  = 1024,
  parameter int unsigned XSLEEP_MULT = 8,
  parameter int unsigned CW          = 20
) (
  input  ldsel_e              sel,
  input  logic [SLEEP_W-1:0]  sleep_fld,
  input  logic                xsleep,
  input  logic [1:0]          baud,
  output logic [CW-1:0]       load_val
);

  always_comb begin
    case (sel)
      LD_PLL:  load_val = CW'(PLL_HALF);
      LD_SIG:  load_val = CW'(sig_half(baud));
      default: load_val = CW'(sleep_half(int'(sleep_fld), xsleep,
                                         SLEEP_UNIT, XSLEEP_MULT));
    endcase
  end

endmodule

// File: rtl/rxpoll_timer.sv
module rxpoll_timer #(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          htick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= load_val;
    else if (htick && cnt != '0)     cnt <= cnt - 1'b1;
  end

  // done when empty, or when the last half period is being consumed
  assign expire = (cnt == '0) | (htick & (cnt == CW'(1)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !htick) |=> $stable(cnt));

  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && htick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rxpoll_fsm.sv
module rxpoll_fsm
  import rxpoll_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  logic   sleep_nz,
  input  logic   cfg_cont,
  input  logic   chk_valid,
  input  logic   chk_pass,
  input  logic   idle_req,
  input  logic   expire,
  output phase_e st,
  output logic   load,
  output ldsel_e ld_sel,
  output logic   vsout,
  output logic   clkon,
  output logic   opm0,
  output logic   awake
);

  phase_e nxt;
  logic   chk_ok_ev;
  logic   chk_bad_ev;

  assign chk_ok_ev  = (st == PH_CHK) && chk_valid && chk_pass;
  assign chk_bad_ev = (st == PH_CHK) && chk_valid && !chk_pass;

  always_comb begin
    nxt    = st;
    load   = 1'b0;
    ld_sel = LD_SLEEP;
    if (idle_req) begin
      nxt = PH_IDLE;
    end else begin
      case (st)
        PH_IDLE: if (!cs_n) begin
          nxt = PH_SLEEP; load = 1'b1; ld_sel = LD_SLEEP;
        end
        PH_SLEEP: if (expire) begin
          if (cs_n) nxt = PH_IDLE;
          else begin nxt = PH_PLL; load = 1'b1; ld_sel = LD_PLL; end
        end
        PH_PLL: if (expire) begin
          nxt = PH_SIG; load = 1'b1; ld_sel = LD_SIG;
        end
        PH_SIG: if (expire) nxt = PH_CHK;
        PH_CHK: begin
          if (chk_ok_ev) nxt = PH_RCV;
          else if (chk_bad_ev && !opm0 && sleep_nz) begin
            nxt = PH_SLEEP; load = 1'b1; ld_sel = LD_SLEEP;
          end
        end
        PH_RCV:  nxt = PH_RCV;
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsout <= 1'b0;
      clkon <= 1'b0;
      opm0  <= 1'b0;
    end else if (st == PH_IDLE || nxt == PH_IDLE) begin
      vsout <= 1'b0;
      clkon <= 1'b0;
      opm0  <= cfg_cont;
    end else if (chk_ok_ev) begin
      vsout <= 1'b1;
      clkon <= 1'b1;
      opm0  <= 1'b1;
    end
  end

  assign awake = (st != PH_IDLE) && (st != PH_SLEEP);

  assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok_ev && !idle_req) |=> (st == PH_RCV && vsout && clkon && opm0));

  assert_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_bad_ev && !idle_req && !opm0 && sleep_nz) |=> (st == PH_SLEEP));

  assert_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_bad_ev && !idle_req && (opm0 || !sleep_nz)) |=> (st == PH_CHK));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SLEEP && expire && !idle_req)
      |=> (st == ($past(cs_n) ? PH_IDLE : PH_PLL)));

  assert_rcv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_RCV && !idle_req) |=> (st == PH_RCV));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |=> (st == PH_IDLE));

endmodule

// File: rtl/rxpoll_seq.sv
module rxpoll_seq
  import rxpoll_pkg::*;
#(
  parameter int unsigned SLEEP_W     = 5,
  parameter int unsigned SLEEP_UNIT  = 1024,
  parameter int unsigned XSLEEP_MULT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               htick,
  input  logic               cs_n,
  input  logic [SLEEP_W-1:0] cfg_sleep,
  input  logic               cfg_xsleep,
  input  logic [1:0]         cfg_baud,
  input  logic               cfg_cont,
  input  logic               chk_valid,
  input  logic               chk_pass,
  input  logic               idle_req,
  input  logic               rx_data,
  output logic [2:0]         phase_o,
  output logic               rx_active,
  output logic               pll_en,
  output logic               sig_en,
  output logic               ctl_vsout,
  output logic               ctl_clk,
  output logic               ctl_opm0,
  output logic               data_out
);

  localparam int unsigned CW = ctr_width(SLEEP_W, SLEEP_UNIT, XSLEEP_MULT);

  phase_e        st_w;
  logic          load_w;
  ldsel_e        sel_w;
  logic [CW-1:0] load_val_w;
  logic [CW-1:0] cnt_w;
  logic          expire_w;
  logic          awake_w;
  logic          sleep_nz_w;

  assign sleep_nz_w = |cfg_sleep;

  rxpoll_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sleep_nz  (sleep_nz_w),
    .cfg_cont  (cfg_cont),
    .chk_valid (chk_valid),
    .chk_pass  (chk_pass),
    .idle_req  (idle_req),
    .expire    (expire_w),
    .st        (st_w),
    .load      (load_w),
    .ld_sel    (sel_w),
    .vsout     (ctl_vsout),
    .clkon     (ctl_clk),
    .opm0      (ctl_opm0),
    .awake     (awake_w)
  );

  rxpoll_dursel #(
    .SLEEP_W     (SLEEP_W),
    .SLEEP_UNIT  (SLEEP_UNIT),
    .XSLEEP_MULT (XSLEEP_MULT),
    .CW          (CW)
  ) u_dursel (
    .sel       (sel_w),
    .sleep_fld (cfg_sleep),
    .xsleep    (cfg_xsleep),
    .baud      (cfg_baud),
    .load_val  (load_val_w)
  );

  rxpoll_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .htick    (htick),
    .load     (load_w),
    .load_val (load_val_w),
    .cnt      (cnt_w),
    .expire   (expire_w)
  );

  assign phase_o   = st_w;
  assign rx_active = awake_w;
  assign pll_en    = awake_w;
  assign sig_en    = awake_w;
  assign data_out  = (st_w == PH_RCV) ? rx_data : 1'b0;

  assert_pll_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == PH_PLL && $past(st_w) != PH_PLL) |-> (cnt_w == CW'(PLL_HALF)));

  assert_sig_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == PH_SIG && $past(st_w) != PH_SIG) |-> ($past(st_w) == PH_PLL));

  assert_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> (st_w == PH_PLL && $past(st_w) == PH_SLEEP));

endmodule

// File: tb/rxpoll_seq_tb_top.sv
module rxpoll_seq_tb_top;

  localparam int CLK_P = 10;
  localparam int SW    = 5;
  localparam int UNIT  = 4;
  localparam int MULT  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          htick, cs_n, cfg_xsleep, cfg_cont;
  logic [SW-1:0] cfg_sleep;
  logic [1:0]    cfg_baud;
  logic          chk_valid, chk_pass, idle_req, rx_data;
  logic [2:0]    phase_o;
  logic          rx_active, pll_en, sig_en, ctl_vsout, ctl_clk, ctl_opm0, data_out;

  int checks = 0;
  int fails  = 0;
  int sig_tab [4] = '{1764, 996, 612, 420};

  rxpoll_seq #(.SLEEP_W(SW), .SLEEP_UNIT(UNIT), .XSLEEP_MULT(MULT)) dut_i (
    .clk(clk), .rst_n(rst_n), .htick(htick), .cs_n(cs_n),
    .cfg_sleep(cfg_sleep), .cfg_xsleep(cfg_xsleep), .cfg_baud(cfg_baud),
    .cfg_cont(cfg_cont), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .idle_req(idle_req), .rx_data(rx_data), .phase_o(phase_o),
    .rx_active(rx_active), .pll_en(pll_en), .sig_en(sig_en),
    .ctl_vsout(ctl_vsout), .ctl_clk(ctl_clk), .ctl_opm0(ctl_opm0),
    .data_out(data_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  function automatic int exp_sleep(input int f, input int x);
    int s;
    s = f * UNIT * 2;
    if (x != 0) s = s * MULT;
    return (s == 0) ? 1 : s;
  endfunction

  // count cycles spent in phase p (R5 enables also checked per cycle)
  task automatic measure(input int p, output int n);
    int bad;
    n = 0; bad = 0;
    while (int'(phase_o) == p && n < 20000) begin
      if (rx_active != (p >= 2) || pll_en != (p >= 2) || sig_en != (p >= 2)) bad++;
      n++;
      @(negedge clk);
    end
    check(bad == 0, "R5 enables per cycle", bad, 0);
  endtask

  task automatic go_idle();
    @(negedge clk);
    cs_n = 1'b1; idle_req = 1'b1; chk_valid = 1'b0;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  task automatic start(input int f, input int x, input int b, input bit cont);
    cfg_sleep = SW'(f); cfg_xsleep = x[0]; cfg_baud = 2'(b); cfg_cont = cont;
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic reach_chk(input int f, input int x, input int b, input bit cont);
    int n;
    go_idle();
    start(f, x, b, cont);
    measure(1, n);
    measure(2, n);
    measure(3, n);
  endtask

  initial begin
    int n;
    int fl [3] = '{0, 1, 31};
    rst_n = 1'b0; htick = 1'b1; cs_n = 1'b1; cfg_sleep = '0; cfg_xsleep = 1'b0;
    cfg_baud = 2'd0; cfg_cont = 1'b0; chk_valid = 1'b0; chk_pass = 1'b0;
    idle_req = 1'b0; rx_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_o == 3'd0, "R1 reset phase", phase_o, 0);
    check({rx_active, pll_en, sig_en} == 3'b000, "R5 reset enables", {rx_active, pll_en, sig_en}, 0);
    check({ctl_vsout, ctl_clk, ctl_opm0} == 3'b000, "R6 reset ctl", {ctl_vsout, ctl_clk, ctl_opm0}, 0);
    repeat (5) @(negedge clk);
    check(phase_o == 3'd0, "R8 idle waits for cs_n", phase_o, 0);

    // sweep of baud range, extension and sleep field
    for (int b = 0; b < 4; b++) begin
      for (int x = 0; x < 2; x++) begin
        for (int k = 0; k < 3; k++) begin
          go_idle();
          start(fl[k], x, b, 1'b0);
          check(phase_o == 3'd1, "R1 enter sleep", phase_o, 1);
          measure(1, n);
          check(n == exp_sleep(fl[k], x), "R2 sleep length", n, exp_sleep(fl[k], x));
          measure(2, n);
          check(n == 1597, "R3 pll length", n, 1597);
          measure(3, n);
          check(n == sig_tab[b], "R4 sig length", n, sig_tab[b]);
          check(phase_o == 3'd4 && rx_active, "R1 reach bitcheck", phase_o, 4);
          chk_valid = 1'b1; chk_pass = 1'b1;
          @(negedge clk);
          chk_valid = 1'b0;
          check(phase_o == 3'd5, "R6 pass to receive", phase_o, 5);
          check({ctl_vsout, ctl_clk, ctl_opm0} == 3'b111, "R6 ctl set",
                {ctl_vsout, ctl_clk, ctl_opm0}, 7);
        end
      end
    end

    // R9 data pass-through and ignored checks in receive
    rx_data = 1'b1; #1;
    check(data_out == 1'b1, "R9 data high", data_out, 1);
    rx_data = 1'b0; #1;
    check(data_out == 1'b0, "R9 data low", data_out, 0);
    chk_valid = 1'b1; chk_pass = 1'b0;
    repeat (3) @(negedge clk);
    chk_valid = 1'b0;
    check(phase_o == 3'd5, "R9 receive holds", phase_o, 5);

    // R10 idle return from receive clears ctl, opm0 follows cfg_cont
    cfg_cont = 1'b0; cs_n = 1'b1; idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    check(phase_o == 3'd0, "R10 idle from receive", phase_o, 0);
    @(negedge clk);
    check({ctl_vsout, ctl_clk, ctl_opm0} == 3'b000, "R10 ctl cleared",
          {ctl_vsout, ctl_clk, ctl_opm0}, 0);
    cfg_cont = 1'b1;
    @(negedge clk);
    check(ctl_opm0 == 1'b1, "R10 opm0 tracks cfg_cont", ctl_opm0, 1);

    // R7 failed check with opm0=0 and non-zero sleep returns to sleep
    reach_chk(1, 0, 3, 1'b0);
    chk_valid = 1'b1; chk_pass = 1'b0;
    @(negedge clk);
    chk_valid = 1'b0;
    check(phase_o == 3'd1, "R7 fail to sleep", phase_o, 1);
    check(rx_active == 1'b0 && pll_en == 1'b0, "R5 low after return", rx_active, 0);
    rx_data = 1'b1; #1;
    check(data_out == 1'b0, "R9 data gated outside receive", data_out, 0);
    rx_data = 1'b0;
    // R1 check strobes ignored in sleep
    chk_valid = 1'b1; chk_pass = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    check(phase_o == 3'd1 || phase_o == 3'd2, "R1 strobe ignored in sleep", phase_o, 1);

    // R7 zero sleep field: failure stays in bit-check
    reach_chk(0, 0, 2, 1'b0);
    chk_valid = 1'b1; chk_pass = 1'b0;
    @(negedge clk);
    chk_valid = 1'b0;
    check(phase_o == 3'd4, "R7 stay sleep=0", phase_o, 4);

    // R7 opm0=1: failure stays in bit-check
    reach_chk(1, 1, 1, 1'b1);
    check(ctl_opm0 == 1'b1, "R10 opm0 loaded from cfg_cont", ctl_opm0, 1);
    chk_valid = 1'b1; chk_pass = 1'b0;
    @(negedge clk);
    chk_valid = 1'b0;
    check(phase_o == 3'd4, "R7 stay opm0=1", phase_o, 4);

    // R8 chip select high at end of sleep goes to idle
    go_idle();
    start(5, 0, 0, 1'b0);
    cs_n = 1'b1;
    measure(1, n);
    check(phase_o == 3'd0, "R8 abort to idle", phase_o, 0);
    check(n == exp_sleep(5, 0), "R2 sleep length before abort", n, exp_sleep(5, 0));

    // R11 stall with htick low in PLL start-up
    go_idle();
    start(0, 0, 0, 1'b0);
    measure(1, n);
    repeat (100) @(negedge clk);
    htick = 1'b0;
    repeat (40) @(negedge clk);
    check(phase_o == 3'd2, "R11 held in pll", phase_o, 2);
    htick = 1'b1;
    measure(2, n);
    check(n == 1497, "R11 remaining pll length", n, 1497);

    // R10 idle return from PLL start-up
    idle_req = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    check(phase_o == 3'd0 && !pll_en, "R10 idle from start-up", phase_o, 0);

    summary();
  end

endmodule